// File: doc/BRIEF.md
# Fractional Clock Divider with Commit Trigger

This block turns a fast input clock into a stream of single-cycle clock-enable pulses whose average rate is the input rate divided by a fractional divisor. The divisor is held in fixed point with `FRAC_W` fraction bits. It is stored offset by one, so a field of zero means divide by exactly 1.0. A phase accumulator gains one whole unit (2^FRAC_W) per input cycle. Each time it reaches the scaled divisor it emits a pulse and keeps the remainder.

Software reaches the block through one 32-bit register. Writing the register loads a shadow copy of the divide field and of a source-select field. The select field drives an external input multiplexer. Neither shadow value takes effect until software sets a commit bit. The commit bit reads back as 1 while the request is pending and clears itself once the new value has been applied. The change is applied only right after an output pulse, so the old ratio never produces a shortened period.

A parameter adds a separate commit bit for the selector; without it, the regular commit bit updates both fields. A second parameter locks the divisor to a fixed value. While a commit is pending, the pulse stream is forced on even if the run enable is low.

Top module: `fdiv_top`

## Requirements
- R1: After reset the register reads 0 and `src_sel` is 0. The live divide field is 0, so the accumulator would pulse on every cycle, and `clk_en` stays low while `run_en` is low.
- R2: The scaled divisor is the live field plus 2^FRAC_W. With `run_en` high, `clk_en` pulses on a cycle exactly when the accumulator plus 2^FRAC_W is at least the scaled divisor. A field of 0 pulses every cycle and a field of 4 (FRAC_W=2) pulses every second cycle.
- R3: Fraction bits give fractional ratios. With FRAC_W=2, field 2 (divisor 1.5) gives 2 pulses in every 3 cycles, and the all-ones field 63 (divisor 16.75) gives 4 pulses in every 67 cycles, both counted from a commit.
- R4: Register layout: divide field in bits [DIV_W-1:0], select field in bits [9:8], commit bit 16, selector commit bit 17. All other bits read 0. A write that sets no commit bit changes only the readback, never the pulse rate.
- R5: Writing 1 to bit 16 makes it read 1 from the next cycle on. It clears on the cycle after the first pulse cycle. The new divisor applies from that cycle with the accumulator cleared.
- R6: With the selector commit enabled, bit 17 alone moves the shadow select to `src_sel`, and bit 16 alone leaves `src_sel` unchanged. Without it, bit 16 commits both fields and bit 17 is ignored and reads 0.
- R7: While either commit bit is pending, every pulse cycle drives `clk_en` high even with `run_en` low. Gating returns once the commit completes.
- R8: A select value of `N_SRC` or more leaves `src_sel` unchanged when committed, and the commit bit still clears.
- R9: With the fixed-divisor variant, the divide field has no effect on the pulse rate. The divisor comes from `FIXED_FIELD` (4 gives one pulse every second cycle).
- R10: With `run_en` low and no commit pending, `clk_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data for the control register |
| reg_rdata | output | 32 | Shadow fields and pending commit bits |
| run_en | input | 1 | Software enable for the output pulse stream |
| src_sel | output | SEL_W | Live select for the external input multiplexer |
| clk_en | output | 1 | Clock-enable pulse stream |

## Verification
The assertions assume `rst_n` is held for at least one edge and that `reg_wr` is a one-cycle strobe whose data is stable around the sampling edge. They place no limit on how often commits are requested, because a fresh request simply stays pending until the next pulse. The stimulus changes inputs only just after a rising edge. Before issuing the next request, it waits for the pending commit bit to read 0, so every counted window starts from a cleared accumulator.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int REG_W    = 32;
    localparam int SEL_POS  = 8;
    localparam int TRIG_POS = 16;
    localparam int PRE_POS  = 17;
endpackage

// File: rtl/fdiv_shadow.sv
module fdiv_shadow #(
    parameter int DIV_W   = 6,
    parameter int SEL_W   = 2,
    parameter bit HAS_PRE = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [fdiv_pkg::REG_W-1:0] wdata,
    input  logic                     tick,
    output logic [DIV_W-1:0]         shadow_div,
    output logic [SEL_W-1:0]         shadow_sel,
    output logic                     div_pend,
    output logic                     sel_pend,
    output logic                     apply_div,
    output logic                     apply_sel,
    output logic [fdiv_pkg::REG_W-1:0] rdata
);
    import fdiv_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             trig;
        logic             pre;
    } shd_t;

    shd_t s_q, s_d;
    logic wdata_unused;

    assign wdata_unused = ^wdata;

    always_comb begin
        s_d      = s_q;
        s_d.trig = s_q.trig & ~tick;
        s_d.pre  = s_q.pre & ~tick;
        if (wr_en) begin
            s_d.div = wdata[DIV_W-1:0];
            s_d.sel = wdata[SEL_POS +: SEL_W];
            if (wdata[TRIG_POS]) begin
                s_d.trig = 1'b1;
            end
            if (HAS_PRE && wdata[PRE_POS]) begin
                s_d.pre = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        if (HAS_PRE) begin : g_pre
            assign sel_pend = s_q.pre;
        end else begin : g_nopre
            assign sel_pend = s_q.trig;
        end
    endgenerate

    assign div_pend   = s_q.trig;
    assign apply_div  = s_q.trig & tick;
    assign apply_sel  = sel_pend & tick;
    assign shadow_div = s_q.div;
    assign shadow_sel = s_q.sel;

    always_comb begin
        rdata                     = '0;
        rdata[DIV_W-1:0]          = s_q.div;
        rdata[SEL_POS +: SEL_W]   = s_q.sel;
        rdata[TRIG_POS]           = s_q.trig;
        rdata[PRE_POS]            = s_q.pre;
    end
endmodule

// File: rtl/fdiv_phase.sv
module fdiv_phase #(
    parameter int INT_W       = 4,
    parameter int FRAC_W      = 2,
    parameter bit FIXED       = 1'b0,
    parameter int FIXED_FIELD = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [INT_W+FRAC_W-1:0] load_field,
    output logic                    tick
);
    localparam int DIV_W = INT_W + FRAC_W;
    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

    typedef struct packed {
        logic [DIV_W-1:0] live;
        logic [ACC_W-1:0] acc;
    } ph_t;

    ph_t p_q, p_d;
    logic [DIV_W-1:0] eff_field;
    logic [ACC_W-1:0] scaled;
    logic [ACC_W-1:0] sum;

    generate
        if (FIXED) begin : g_fixed
            assign eff_field = DIV_W'(FIXED_FIELD);
        end else begin : g_prog
            assign eff_field = p_q.live;
        end
    endgenerate

    assign scaled = {1'b0, eff_field} + ONE;
    assign sum    = p_q.acc + ONE;
    assign tick   = (sum >= scaled);

    always_comb begin
        p_d = p_q;
        if (load) begin
            p_d.live = load_field;
            p_d.acc  = '0;
        end else if (tick) begin
            p_d.acc = sum - scaled;
        end else begin
            p_d.acc = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top #(
    parameter int INT_W       = 4,
    parameter int FRAC_W      = 2,
    parameter int SEL_W       = 2,
    parameter int N_SRC       = 3,
    parameter bit HAS_PRE     = 1'b1,
    parameter bit FIXED       = 1'b0,
    parameter int FIXED_FIELD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             run_en,
    output logic [SEL_W-1:0] src_sel,
    output logic             clk_en
);
    localparam int DIV_W = INT_W + FRAC_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } top_t;

    top_t t_q, t_d;

    logic [DIV_W-1:0] shadow_div;
    logic [SEL_W-1:0] shadow_sel;
    logic             div_pend;
    logic             sel_pend;
    logic             apply_div;
    logic             apply_sel;
    logic             tick;
    logic             sel_ok;

    fdiv_shadow #(.DIV_W(DIV_W), .SEL_W(SEL_W), .HAS_PRE(HAS_PRE)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wdata      (reg_wdata),
        .tick       (tick),
        .shadow_div (shadow_div),
        .shadow_sel (shadow_sel),
        .div_pend   (div_pend),
        .sel_pend   (sel_pend),
        .apply_div  (apply_div),
        .apply_sel  (apply_sel),
        .rdata      (reg_rdata)
    );

    fdiv_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W), .FIXED(FIXED),
                 .FIXED_FIELD(FIXED_FIELD)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (apply_div),
        .load_field (shadow_div),
        .tick       (tick)
    );

    assign sel_ok = ({1'b0, shadow_sel} < (SEL_W+1)'(N_SRC));

    always_comb begin
        t_d = t_q;
        if (apply_sel && sel_ok) begin
            t_d.sel = shadow_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign src_sel = t_q.sel;
    assign clk_en  = tick & (run_en | div_pend | sel_pend);
endmodule

// File: rtl/fdiv_check.sv
module fdiv_check #(
    parameter int SEL_W = 2,
    parameter int N_SRC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             clk_en,
    input logic             tick,
    input logic             div_pend,
    input logic             sel_pend,
    input logic [SEL_W-1:0] src_sel
);
    assert_gate_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !div_pend && !sel_pend) |-> !clk_en);

    assert_force_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((div_pend || sel_pend) && tick) |-> clk_en);

    assert_hold_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pend && !tick) |=> div_pend);

    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_pend && tick) |=> $stable(src_sel));

    assert_sel_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, src_sel} < (SEL_W+1)'(N_SRC)));

    assert_pulse_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> !clk_en);
endmodule

bind fdiv_top fdiv_check #(.SEL_W(SEL_W), .N_SRC(N_SRC)) u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .clk_en   (clk_en),
    .tick     (tick),
    .div_pend (div_pend),
    .sel_pend (sel_pend),
    .src_sel  (src_sel)
);

// File: tb/fdiv_top_test.sv
module fdiv_top_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, reg_wr, run_en, clk_en;
    logic [31:0] reg_wdata, reg_rdata;
    logic [1:0]  src_sel;

    logic        fx_wr, fx_run, fx_en;
    logic [31:0] fx_wdata, fx_rdata;
    logic [1:0]  fx_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    fdiv_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .run_en(run_en), .src_sel(src_sel), .clk_en(clk_en)
    );

    fdiv_top #(.HAS_PRE(1'b0), .FIXED(1'b1), .FIXED_FIELD(4)) uut_fx (
        .clk(clk), .rst_n(rst_n), .reg_wr(fx_wr), .reg_wdata(fx_wdata),
        .reg_rdata(fx_rdata), .run_en(fx_run), .src_sel(fx_sel), .clk_en(fx_en)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model of the main instance
    int m_div, m_sel, m_trig, m_pre, m_live, m_acc, m_lsel;
    int tk, ad, as_, od, os;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_sel = 0; m_trig = 0; m_pre = 0;
            m_live = 0; m_acc = 0; m_lsel = 0;
        end else begin
            tk  = (m_acc + 4 >= m_live + 4) ? 1 : 0;
            ad  = m_trig & tk;
            as_ = m_pre & tk;
            od  = m_div;
            os  = m_sel;
            m_trig = ((m_trig != 0 && tk == 0) || (reg_wr && reg_wdata[16])) ? 1 : 0;
            m_pre  = ((m_pre != 0 && tk == 0) || (reg_wr && reg_wdata[17])) ? 1 : 0;
            if (reg_wr) begin
                m_div = int'(reg_wdata[5:0]);
                m_sel = int'(reg_wdata[9:8]);
            end
            if (ad != 0) begin
                m_live = od;
                m_acc  = 0;
            end else if (tk != 0) begin
                m_acc = m_acc + 4 - (m_live + 4);
            end else begin
                m_acc = m_acc + 4;
            end
            if (as_ != 0 && os < 3) m_lsel = os;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic int e_tk = (m_acc + 4 >= m_live + 4) ? 1 : 0;
            automatic int e_en = (e_tk != 0 && (run_en || m_trig != 0 || m_pre != 0)) ? 1 : 0;
            automatic int e_rd = m_div | (m_sel << 8) | (m_trig << 16) | (m_pre << 17);
            chk(int'(clk_en) == e_en, "R2 pulse stream", clk_en, e_en);
            chk(int'(reg_rdata) == e_rd, "R4 readback", reg_rdata, e_rd);
            chk(int'(src_sel) == m_lsel, "R6 live select", src_sel, m_lsel);
        end
    end

    task automatic wr_reg(input logic [31:0] v);
        @(posedge clk); #1 reg_wr = 1'b1; reg_wdata = v;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic wait_clear(input int pos, input string tag);
        @(negedge clk);
        chk(reg_rdata[pos] == 1'b1, tag, reg_rdata[pos], 1);
        for (int i = 0; i < 300 && reg_rdata[pos]; i++) @(negedge clk);
        chk(reg_rdata[pos] == 1'b0, tag, reg_rdata[pos], 0);
    endtask

    task automatic count_en(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            if (clk_en) cnt++;
        end
    endtask

    task automatic count_fx(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (fx_en) cnt++;
        end
    endtask

    initial begin
        #(50000 * 10);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; run_en = 1'b0;
        fx_wr = 1'b0; fx_wdata = '0; fx_run = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(reg_rdata == 32'h0, "R1 reset readback", reg_rdata, 0);
        chk(src_sel == 2'd0, "R1 reset select", src_sel, 0);
        chk(clk_en == 1'b0, "R1 gated after reset", clk_en, 0);

        @(posedge clk); #1 run_en = 1'b1;
        @(negedge clk);
        count_en(10, c);
        chk(c == 10, "R2 divide by 1.0", c, 10);

        wr_reg(32'h0000_0004);
        @(negedge clk);
        count_en(8, c);
        chk(c == 8, "R4 shadow write without commit", c, 8);

        wr_reg(32'h0001_0004);
        wait_clear(16, "R5 commit bit");
        count_en(20, c);
        chk(c == 10, "R2 divide by 2.0", c, 10);

        wr_reg(32'h0001_0002);
        wait_clear(16, "R5 commit bit");
        count_en(30, c);
        chk(c == 20, "R3 divide by 1.5", c, 20);

        wr_reg(32'h0001_003F);
        wait_clear(16, "R5 commit bit");
        count_en(134, c);
        chk(c == 8, "R3 divide by 16.75", c, 8);

        wr_reg(32'h0002_023F);
        wait_clear(17, "R6 selector commit bit");
        chk(src_sel == 2'd2, "R6 selector commit", src_sel, 2);

        wr_reg(32'h0001_0100);
        wait_clear(16, "R6 divider commit only");
        chk(src_sel == 2'd2, "R6 regular commit leaves select", src_sel, 2);

        wr_reg(32'h0002_0300);
        wait_clear(17, "R8 commit clears");
        chk(src_sel == 2'd2, "R8 out-of-range select ignored", src_sel, 2);

        @(posedge clk); #1 run_en = 1'b0;
        wr_reg(32'h0001_0004);
        @(negedge clk);
        chk(reg_rdata[16] == 1'b1, "R7 pending", reg_rdata[16], 1);
        chk(clk_en == 1'b1, "R7 forced pulse while pending", clk_en, 1);
        @(negedge clk);
        chk(reg_rdata[16] == 1'b0, "R7 commit done", reg_rdata[16], 0);
        count_en(10, c);
        chk(c == 0, "R10 gated with run_en low", c, 0);

        @(posedge clk); #1 fx_run = 1'b1;
        count_fx(20, c);
        chk(c == 10, "R9 fixed divisor", c, 10);
        @(posedge clk); #1 fx_wr = 1'b1; fx_wdata = 32'h0003_0200;
        @(posedge clk); #1 fx_wr = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (!fx_rdata[16]) break;
        end
        chk(fx_rdata[16] == 1'b0, "R6 single commit clears", fx_rdata[16], 0);
        chk(fx_sel == 2'd2, "R6 single commit moves select", fx_sel, 2);
        chk(fx_rdata[17] == 1'b0, "R6 selector bit ignored", fx_rdata[17], 0);
        count_fx(20, c);
        chk(c == 10, "R9 field ignored in fixed mode", c, 10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule